// File: doc/BRIEF.md
# Battery Current Fault Delay Protector

This block sits between four current comparators on a battery pack's sense resistor and the two protection FET gate drivers. Each comparator reports one fault condition: overcurrent while discharging, a first and a second short-circuit level while discharging, and a short circuit while charging. A comparator must stay asserted for a programmed number of low-frequency tick periods before its fault is accepted. An accepted fault latches, and the matching gate enable goes low. The latch is released only by an explicit clear pulse.

Time is counted in periods of a 32.768 kHz tick, which is supplied as a one-cycle enable strobe in the fast clock domain. One tick period is about 30.5 µs. Each fault type has its own delay code and its own step size. A doubling bit widens the steps of the two discharge short-circuit delays. The block also turns the threshold codes into millivolt magnitudes for the comparator reference logic. A sense-range bit halves both the base and the step of every threshold. The charge short-circuit threshold is reported with negative sign.

Top module: `fdp_current_guard`

## Requirements
- R1: After reset, all four bits of `fault_flags` are 0 and both `dsg_en` and `chg_en` are 1.
- R2: The fault flag bit order is fixed: bit 0 discharge overcurrent, bit 1 first discharge short circuit, bit 2 second discharge short circuit, bit 3 charge short circuit. The overcurrent flag sets on tick number `OCD_BASE_TICKS + OCD_STEP_TICKS*ocd_dly + 1` counted while `cmp_ocd` stays high, and not on any earlier tick.
- R3: The first discharge short-circuit delay is `2*SC_UNIT_TICKS*scd1_dly` ticks, doubled when `sc_dbl` is 1. Its flag sets on the following tick.
- R4: The second discharge short-circuit delay is `SC_UNIT_TICKS*scd2_dly` ticks, doubled when `sc_dbl` is 1. Its flag sets on the following tick.
- R5: The charge short-circuit delay is `2*SC_UNIT_TICKS*scc_dly` ticks, and `sc_dbl` has no effect on it.
- R6: With a delay of zero, the flag sets on the first tick that sees its comparator high.
- R7: If a comparator goes low for even one clock cycle before its flag sets, its count restarts from zero and no flag is raised.
- R8: Delay counts advance only on clock cycles where `tick` is 1.
- R9: A set flag stays set while its comparator is low, until `fault_clr` is high on a clock edge. The clear takes priority over a set in the same cycle. After a clear, a comparator that is still high starts a full new delay.
- R10: `dsg_en` is 0 while any of flag bits 0 to 2 is set. `chg_en` is 0 while flag bit 3 is set. Each gate enable ignores the other group's flags.
- R11: `ocd_thr_mv` is `50 + 10*code` when `sense_hi` is 0, and `25 + 5*code` when `sense_hi` is 1.
- R12: Each discharge short-circuit threshold is `100 + 50*code` when `sense_hi` is 0, or `50 + 25*code` when it is 1. `scc_thr_mv` is the negative of the same formula, with the magnitude capped at 300 when `sense_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| cmp_ocd | input | 1 | Discharge overcurrent comparator |
| cmp_scd1 | input | 1 | First discharge short-circuit comparator |
| cmp_scd2 | input | 1 | Second discharge short-circuit comparator |
| cmp_scc | input | 1 | Charge short-circuit comparator |
| sense_hi | input | 1 | Sense-range bit; halves threshold base and step |
| sc_dbl | input | 1 | Doubles both discharge short-circuit delay steps |
| ocd_dly | input | CODE_W | Overcurrent delay code |
| scd1_dly | input | CODE_W | First short-circuit delay code |
| scd2_dly | input | CODE_W | Second short-circuit delay code |
| scc_dly | input | CODE_W | Charge short-circuit delay code |
| ocd_thr_code | input | 4 | Overcurrent threshold code |
| scd1_thr_code | input | 3 | First short-circuit threshold code |
| scd2_thr_code | input | 3 | Second short-circuit threshold code |
| scc_thr_code | input | 3 | Charge short-circuit threshold code |
| fault_clr | input | 1 | Clears all latched flags |
| fault_flags | output | 4 | Latched fault flags, bit order as in R2 |
| dsg_en | output | 1 | Discharge FET gate enable |
| chg_en | output | 1 | Charge FET gate enable |
| ocd_thr_mv | output | THR_W | Overcurrent threshold in mV |
| scd1_thr_mv | output | THR_W | First short-circuit threshold in mV |
| scd2_thr_mv | output | THR_W | Second short-circuit threshold in mV |
| scc_thr_mv | output | THR_W | Charge short-circuit threshold in mV, signed |

## Verification
The bench builds the block with `OCD_BASE_TICKS` = 3 and `OCD_STEP_TICKS` = 4, and keeps `SC_UNIT_TICKS` = 1 and `CODE_W` = 4. With these values the largest overcurrent delay, 63 ticks, fills the derived counter exactly. That brings the counter's top value into a short run. The doubled short-circuit maximum of 60 ticks sits close to the same boundary. Ticks are spaced by idle cycles, so the bench can show that counting waits for `tick`.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  localparam int NUM_FAULTS = 4;

  typedef enum logic [1:0] {
    F_OCD  = 2'd0,
    F_SCD1 = 2'd1,
    F_SCD2 = 2'd2,
    F_SCC  = 2'd3
  } fault_e;

  // threshold scaling in millivolts for the low-sensitivity range;
  // the high-sensitivity range uses half of each value
  localparam int OCD_BASE_MV = 50;
  localparam int OCD_STEP_MV = 10;
  localparam int SC_BASE_MV  = 100;
  localparam int SC_STEP_MV  = 50;
  localparam int SCC_CAP_MV  = 300;
endpackage

// File: rtl/fdp_rst_sync.sv
module fdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fdp_delay_map.sv
module fdp_delay_map #(
  parameter int CODE_W         = 4,
  parameter int CNT_W          = 10,
  parameter int OCD_BASE_TICKS = 33,
  parameter int OCD_STEP_TICKS = 66,
  parameter int SC_UNIT_TICKS  = 1
) (
  input  logic                                       sc_dbl,
  input  logic [CODE_W-1:0]                          ocd_dly,
  input  logic [CODE_W-1:0]                          scd1_dly,
  input  logic [CODE_W-1:0]                          scd2_dly,
  input  logic [CODE_W-1:0]                          scc_dly,
  output logic [fdp_pkg::NUM_FAULTS-1:0][CNT_W-1:0]  limit
);
  import fdp_pkg::*;

  localparam logic [CNT_W-1:0] OCD_BASE = CNT_W'(OCD_BASE_TICKS);
  localparam logic [CNT_W-1:0] OCD_STEP = CNT_W'(OCD_STEP_TICKS);
  localparam logic [CNT_W-1:0] WIDE_STEP = CNT_W'(2 * SC_UNIT_TICKS);
  localparam logic [CNT_W-1:0] NARROW_STEP = CNT_W'(SC_UNIT_TICKS);

  logic [CNT_W-1:0] scd1_step;
  logic [CNT_W-1:0] scd2_step;

  always_comb begin
    scd1_step = sc_dbl ? (WIDE_STEP << 1)   : WIDE_STEP;
    scd2_step = sc_dbl ? (NARROW_STEP << 1) : NARROW_STEP;
    limit[int'(F_OCD)]  = OCD_BASE + OCD_STEP * CNT_W'(ocd_dly);
    limit[int'(F_SCD1)] = scd1_step * CNT_W'(scd1_dly);
    limit[int'(F_SCD2)] = scd2_step * CNT_W'(scd2_dly);
    limit[int'(F_SCC)]  = WIDE_STEP * CNT_W'(scc_dly);
  end
endmodule

// File: rtl/fdp_delay_timer.sv
module fdp_delay_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmp,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             fault
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fault_d;

  // next-state logic
  always_comb begin
    cnt_d   = cnt_q;
    fault_d = fault;
    if (clr) begin
      fault_d = 1'b0;
      cnt_d   = '0;
    end else if (fault || !cmp) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= limit) begin
        fault_d = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fault <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fault <= fault_d;
    end
  end

  // R6: zero delay sets the flag on the first qualifying tick
  a_r6_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && cmp && tick && !clr && limit == '0) |=> fault);

  // R7: a low comparator never lets a new flag appear
  a_r7_low_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !cmp) |=> !fault);

  // R8: no flag appears on a cycle without a tick
  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault && !tick) |=> !fault);

  // R9: a latched flag holds until cleared, and clear always drops it
  a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> fault);
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !fault);
endmodule

// File: rtl/fdp_thresh_scale.sv
module fdp_thresh_scale #(
  parameter int THR_W = 10
) (
  input  logic                    sense_hi,
  input  logic [3:0]              ocd_code,
  input  logic [2:0]              scd1_code,
  input  logic [2:0]              scd2_code,
  input  logic [2:0]              scc_code,
  output logic [THR_W-1:0]        ocd_mv,
  output logic [THR_W-1:0]        scd1_mv,
  output logic [THR_W-1:0]        scd2_mv,
  output logic signed [THR_W-1:0] scc_mv
);
  import fdp_pkg::*;

  int ocd_i, scd1_i, scd2_i, scc_i;
  int sc_base, sc_step;

  always_comb begin
    sc_base = sense_hi ? SC_BASE_MV / 2 : SC_BASE_MV;
    sc_step = sense_hi ? SC_STEP_MV / 2 : SC_STEP_MV;
    ocd_i   = sense_hi ? (OCD_BASE_MV / 2 + (OCD_STEP_MV / 2) * int'(ocd_code))
                       : (OCD_BASE_MV + OCD_STEP_MV * int'(ocd_code));
    scd1_i  = sc_base + sc_step * int'(scd1_code);
    scd2_i  = sc_base + sc_step * int'(scd2_code);
    scc_i   = sc_base + sc_step * int'(scc_code);
    if (!sense_hi && scc_i > SCC_CAP_MV) scc_i = SCC_CAP_MV;
    ocd_mv  = THR_W'(ocd_i);
    scd1_mv = THR_W'(scd1_i);
    scd2_mv = THR_W'(scd2_i);
    scc_mv  = THR_W'(-scc_i);
  end
endmodule

// File: rtl/fdp_current_guard.sv
module fdp_current_guard #(
  parameter int CODE_W         = 4,
  parameter int OCD_BASE_TICKS = 33,
  parameter int OCD_STEP_TICKS = 66,
  parameter int SC_UNIT_TICKS  = 1,
  parameter int THR_W          = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    cmp_ocd,
  input  logic                    cmp_scd1,
  input  logic                    cmp_scd2,
  input  logic                    cmp_scc,
  input  logic                    sense_hi,
  input  logic                    sc_dbl,
  input  logic [CODE_W-1:0]       ocd_dly,
  input  logic [CODE_W-1:0]       scd1_dly,
  input  logic [CODE_W-1:0]       scd2_dly,
  input  logic [CODE_W-1:0]       scc_dly,
  input  logic [3:0]              ocd_thr_code,
  input  logic [2:0]              scd1_thr_code,
  input  logic [2:0]              scd2_thr_code,
  input  logic [2:0]              scc_thr_code,
  input  logic                    fault_clr,
  output logic [3:0]              fault_flags,
  output logic                    dsg_en,
  output logic                    chg_en,
  output logic [THR_W-1:0]        ocd_thr_mv,
  output logic [THR_W-1:0]        scd1_thr_mv,
  output logic [THR_W-1:0]        scd2_thr_mv,
  output logic signed [THR_W-1:0] scc_thr_mv
);
  import fdp_pkg::*;

  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int OCD_MAX  = OCD_BASE_TICKS + OCD_STEP_TICKS * CODE_MAX;
  localparam int SC_MAX   = 4 * SC_UNIT_TICKS * CODE_MAX;
  localparam int CNT_W    = $clog2(((OCD_MAX > SC_MAX) ? OCD_MAX : SC_MAX) + 1);

  logic                                rst_sync_n;
  logic [NUM_FAULTS-1:0]               cmp_vec;
  logic [NUM_FAULTS-1:0][CNT_W-1:0]    limit;
  logic [NUM_FAULTS-1:0]               flag_vec;

  fdp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cmp_vec[int'(F_OCD)]  = cmp_ocd;
  assign cmp_vec[int'(F_SCD1)] = cmp_scd1;
  assign cmp_vec[int'(F_SCD2)] = cmp_scd2;
  assign cmp_vec[int'(F_SCC)]  = cmp_scc;

  fdp_delay_map #(
    .CODE_W         (CODE_W),
    .CNT_W          (CNT_W),
    .OCD_BASE_TICKS (OCD_BASE_TICKS),
    .OCD_STEP_TICKS (OCD_STEP_TICKS),
    .SC_UNIT_TICKS  (SC_UNIT_TICKS)
  ) u_map (
    .sc_dbl   (sc_dbl),
    .ocd_dly  (ocd_dly),
    .scd1_dly (scd1_dly),
    .scd2_dly (scd2_dly),
    .scc_dly  (scc_dly),
    .limit    (limit)
  );

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_timer
    fdp_delay_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .tick  (tick),
      .cmp   (cmp_vec[g]),
      .clr   (fault_clr),
      .limit (limit[g]),
      .fault (flag_vec[g])
    );
  end

  fdp_thresh_scale #(.THR_W(THR_W)) u_thr (
    .sense_hi  (sense_hi),
    .ocd_code  (ocd_thr_code),
    .scd1_code (scd1_thr_code),
    .scd2_code (scd2_thr_code),
    .scc_code  (scc_thr_code),
    .ocd_mv    (ocd_thr_mv),
    .scd1_mv   (scd1_thr_mv),
    .scd2_mv   (scd2_thr_mv),
    .scc_mv    (scc_thr_mv)
  );

  // gate enables: discharge group and charge group kept apart
  always_comb begin
    fault_flags = flag_vec;
    dsg_en = !(flag_vec[int'(F_OCD)] || flag_vec[int'(F_SCD1)] || flag_vec[int'(F_SCD2)]);
    chg_en = !flag_vec[int'(F_SCC)];
  end

  // R9: a clear empties every flag on the next cycle
  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_clr |=> (fault_flags == 4'b0000));

  // R10: the charge gate stays on while only discharge flags rise
  a_r10_chg_unaffected: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (chg_en && !cmp_scc) |=> chg_en);

  // R11: overcurrent threshold stays in its sense-range window
  a_r11_ocd_window: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sense_hi |-> (ocd_thr_mv >= THR_W'(25) && ocd_thr_mv <= THR_W'(100)));

  // R12: charge short-circuit threshold is always negative
  a_r12_scc_negative: assert property (@(posedge clk) disable iff (!rst_sync_n)
    scc_thr_mv < 0);
endmodule

// File: tb/fdp_current_guard_test.sv
`timescale 1ns/1ps
module fdp_current_guard_test;
  localparam int THR_W = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic [3:0] cmp;
  logic sense_hi, sc_dbl, fault_clr;
  logic [3:0] ocd_dly, scd1_dly, scd2_dly, scc_dly;
  logic [3:0] ocd_thr_code;
  logic [2:0] scd1_thr_code, scd2_thr_code, scc_thr_code;
  logic [3:0] fault_flags;
  logic dsg_en, chg_en;
  logic [THR_W-1:0] ocd_thr_mv, scd1_thr_mv, scd2_thr_mv;
  logic signed [THR_W-1:0] scc_thr_mv;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fdp_current_guard #(
    .OCD_BASE_TICKS (3),
    .OCD_STEP_TICKS (4)
  ) uut (
    .clk (clk), .rst_n (rst_n), .tick (tick),
    .cmp_ocd (cmp[0]), .cmp_scd1 (cmp[1]), .cmp_scd2 (cmp[2]), .cmp_scc (cmp[3]),
    .sense_hi (sense_hi), .sc_dbl (sc_dbl),
    .ocd_dly (ocd_dly), .scd1_dly (scd1_dly), .scd2_dly (scd2_dly), .scc_dly (scc_dly),
    .ocd_thr_code (ocd_thr_code), .scd1_thr_code (scd1_thr_code),
    .scd2_thr_code (scd2_thr_code), .scc_thr_code (scc_thr_code),
    .fault_clr (fault_clr), .fault_flags (fault_flags),
    .dsg_en (dsg_en), .chg_en (chg_en),
    .ocd_thr_mv (ocd_thr_mv), .scd1_thr_mv (scd1_thr_mv),
    .scd2_thr_mv (scd2_thr_mv), .scc_thr_mv (scc_thr_mv)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk) fault_clr = 1'b1;
    @(negedge clk) fault_clr = 1'b0;
  endtask

  // hold one comparator high and find the tick on which its flag sets
  task automatic run_delay(input int ch, input int lim, input string tag);
    @(negedge clk) cmp[ch] = 1'b1;
    for (int i = 0; i < lim; i++) pulse_tick();
    check({tag, " flag still low"}, int'(fault_flags), 0);
    pulse_tick();
    check({tag, " flag set"}, int'(fault_flags), 1 << ch);
    check({tag, " dsg_en"}, int'(dsg_en), (ch == 3) ? 1 : 0);
    check({tag, " chg_en"}, int'(chg_en), (ch == 3) ? 0 : 1);
    @(negedge clk) cmp[ch] = 1'b0;
    clear_all();
  endtask

  task automatic t_reset();
    check("R1 flags after reset", int'(fault_flags), 0);
    check("R1 dsg_en after reset", int'(dsg_en), 1);
    check("R1 chg_en after reset", int'(chg_en), 1);
  endtask

  task automatic t_ocd();
    ocd_dly = 4'd0;  run_delay(0, 3,  "R2 ocd code0");
    ocd_dly = 4'd5;  run_delay(0, 23, "R2 ocd code5");
    ocd_dly = 4'd15; run_delay(0, 63, "R2 ocd code15");
  endtask

  task automatic t_scd1();
    sc_dbl = 1'b0; scd1_dly = 4'd3;  run_delay(1, 6,  "R3 scd1 code3");
    sc_dbl = 1'b1; scd1_dly = 4'd3;  run_delay(1, 12, "R3 scd1 code3 doubled");
    sc_dbl = 1'b1; scd1_dly = 4'd15; run_delay(1, 60, "R3 scd1 code15 doubled");
    sc_dbl = 1'b0;
  endtask

  task automatic t_scd2();
    sc_dbl = 1'b0; scd2_dly = 4'd7; run_delay(2, 7,  "R4 scd2 code7");
    sc_dbl = 1'b1; scd2_dly = 4'd7; run_delay(2, 14, "R4 scd2 code7 doubled");
    sc_dbl = 1'b0;
  endtask

  task automatic t_scc();
    sc_dbl = 1'b0; scc_dly = 4'd4; run_delay(3, 8, "R5 scc code4");
    sc_dbl = 1'b1; scc_dly = 4'd4; run_delay(3, 8, "R5 scc doubler ignored");
    sc_dbl = 1'b0;
  endtask

  task automatic t_zero();
    scd1_dly = 4'd0; run_delay(1, 0, "R6 zero delay scd1");
    scc_dly  = 4'd0; run_delay(3, 0, "R6 zero delay scc");
  endtask

  task automatic t_drop();
    scd2_dly = 4'd5;
    @(negedge clk) cmp[2] = 1'b1;
    for (int i = 0; i < 5; i++) pulse_tick();
    @(negedge clk) cmp[2] = 1'b0;
    @(negedge clk) cmp[2] = 1'b1;
    for (int i = 0; i < 5; i++) pulse_tick();
    check("R7 no flag after restart", int'(fault_flags), 0);
    pulse_tick();
    check("R7 flag after full restart", int'(fault_flags), 4);
    @(negedge clk) cmp[2] = 1'b0;
    clear_all();
  endtask

  task automatic t_tick_gate();
    scd2_dly = 4'd0;
    @(negedge clk) cmp[2] = 1'b1;
    repeat (10) @(negedge clk);
    check("R8 no flag without tick", int'(fault_flags), 0);
    pulse_tick();
    check("R8 flag on tick", int'(fault_flags), 4);
    @(negedge clk) cmp[2] = 1'b0;
    clear_all();
  endtask

  task automatic t_latch();
    scd2_dly = 4'd2;
    @(negedge clk) cmp[2] = 1'b1;
    for (int i = 0; i < 3; i++) pulse_tick();
    @(negedge clk) cmp[2] = 1'b0;
    for (int i = 0; i < 4; i++) pulse_tick();
    check("R9 flag latched with comparator low", int'(fault_flags), 4);
    check("R9 dsg_en held low", int'(dsg_en), 0);
    clear_all();
    check("R9 flag cleared", int'(fault_flags), 0);
    @(negedge clk) cmp[2] = 1'b1;
    for (int i = 0; i < 3; i++) pulse_tick();
    clear_all();
    check("R9 clear with comparator high", int'(fault_flags), 0);
    for (int i = 0; i < 2; i++) pulse_tick();
    check("R9 fresh delay after clear", int'(fault_flags), 0);
    pulse_tick();
    check("R9 relatch after fresh delay", int'(fault_flags), 4);
    @(negedge clk) cmp[2] = 1'b0;
    clear_all();
  endtask

  task automatic t_gates();
    ocd_dly = 4'd0; scc_dly = 4'd0;
    @(negedge clk) cmp = 4'b1001;
    for (int i = 0; i < 4; i++) pulse_tick();
    check("R10 both groups flagged", int'(fault_flags), 9);
    check("R10 dsg_en low", int'(dsg_en), 0);
    check("R10 chg_en low", int'(chg_en), 0);
    @(negedge clk) cmp = 4'b0000;
    clear_all();
    check("R10 dsg_en restored", int'(dsg_en), 1);
    check("R10 chg_en restored", int'(chg_en), 1);
  endtask

  task automatic t_thresh();
    @(negedge clk) sense_hi = 1'b0; ocd_thr_code = 4'd0; scd1_thr_code = 3'd0;
      scd2_thr_code = 3'd7; scc_thr_code = 3'd4;
    #1;
    check("R11 ocd lo range code0", int'(ocd_thr_mv), 50);
    check("R12 scd1 lo range code0", int'(scd1_thr_mv), 100);
    check("R12 scd2 lo range code7", int'(scd2_thr_mv), 450);
    check("R12 scc lo range code4", int'(scc_thr_mv), -300);
    ocd_thr_code = 4'd15; scc_thr_code = 3'd7;
    #1;
    check("R11 ocd lo range code15", int'(ocd_thr_mv), 200);
    check("R12 scc lo range capped", int'(scc_thr_mv), -300);
    sense_hi = 1'b1; scd1_thr_code = 3'd3;
    #1;
    check("R11 ocd hi range code15", int'(ocd_thr_mv), 100);
    check("R12 scd1 hi range code3", int'(scd1_thr_mv), 125);
    check("R12 scd2 hi range code7", int'(scd2_thr_mv), 225);
    check("R12 scc hi range code7", int'(scc_thr_mv), -225);
    ocd_thr_code = 4'd0;
    #1;
    check("R11 ocd hi range code0", int'(ocd_thr_mv), 25);
    sense_hi = 1'b0;
  endtask

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; cmp = 4'b0000; sense_hi = 1'b0; sc_dbl = 1'b0;
    fault_clr = 1'b0; ocd_dly = '0; scd1_dly = '0; scd2_dly = '0; scc_dly = '0;
    ocd_thr_code = '0; scd1_thr_code = '0; scd2_thr_code = '0; scc_thr_code = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ocd();
    t_scd1();
    t_scd2();
    t_scc();
    t_zero();
    t_drop();
    t_tick_gate();
    t_latch();
    t_gates();
    t_thresh();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule